// File: doc/BRIEF.md
# ADC Result Accumulator and Filter

This block sits behind an analog-to-digital converter and post-processes each result word as it arrives with a valid strobe. A control register holds the operating mode, a shift amount, a previous-value source select and a self-clearing clear command. A second register holds a repeat-count threshold. In the pass-through mode each result is copied to the filtered output. The other modes keep a running accumulator and a sample counter and produce a scaled output:
- continuous accumulation,
- block averaging that resets itself when the threshold is reached,
- triggered burst averaging,
- a first-order low-pass filter with unity DC gain.

A conversion-start strobe does two jobs. It copies either the filtered output or the last raw result into a previous-value register, which a later comparison stage can use. In burst mode it also arms a new burst. The filtered output comes with a one-cycle valid pulse, so downstream logic knows when a new value has been produced. A sticky overflow flag reports a carry out of the accumulator. The flag is dropped only by the clear command, which takes a fixed number of cycles to complete.

Top module: `adc_postproc`

## Requirements
- R1: After reset, every register reads 0. This covers the control register, the threshold, the accumulator, the counter, the overflow flag, the filtered output, the previous value and the output valid. With the control register at 0 the block is in pass-through mode.
- R2: In mode 0 (pass-through) and in the unused codes 5, 6 and 7, a valid sample appears zero-extended on `filt_q` with `filt_vld` one cycle later. The shift field is ignored, and the accumulator and counter do not change.
- R3: In mode 1 (accumulate), each sample is added to the accumulator and the counter increments, saturating at all ones. `filt_q` becomes the new accumulator value shifted right by the effective shift, with `filt_vld` asserted.
- R4: In mode 2 (average), samples accumulate and no output is produced until the counter reaches the threshold. On the sample that reaches it, `filt_q` becomes the sum shifted right, `filt_vld` pulses, and the accumulator and counter return to 0.
- R5: In mode 3 (burst average), a conversion start zeroes the accumulator and counter and arms a burst. The burst then behaves as in R4 and disarms once it has produced its output. Samples that arrive while the block is not armed change nothing.
- R6: In mode 4 (low-pass), each sample updates the accumulator to acc + sample − (acc >> shift), and `filt_q` becomes the new acc >> shift with `filt_vld` asserted.
- R7: The effective shift equals the shift field when the field is 0 to MAX_SH. Larger field values act as MAX_SH (6 by default).
- R8: In modes 1 to 3, a carry out of the accumulator width sets `ovf_q`, and the accumulator keeps the low bits of the sum. Once set, `ovf_q` stays set until a clear completes.
- R9: Writing the control register with bit 7 set makes bit 7 read back as 1 for CLR_CYC cycles. Then the accumulator, the counter and `ovf_q` are zeroed and bit 7 returns to 0. While the clear is pending, modes 1 to 4 ignore samples.
- R10: On `conv_start`, `prev_q` loads `filt_q` when the source bit is 1. When the source bit is 0, it loads the last raw result received before that start.
- R11: The control register reads back as {clear[7], shift[6:4], source[3], mode[2:0]}, and the threshold register reads back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data {clear, shift[2:0], source, mode[2:0]} |
| ctl_rdata | output | 8 | Control register readback; bit 7 shows a pending clear |
| rpt_we | input | 1 | Threshold register write strobe |
| rpt_wdata | input | CNT_W | Threshold write data |
| rpt_rdata | output | CNT_W | Threshold readback |
| conv_start | input | 1 | Start of conversion: loads the previous value and arms a burst |
| smp_valid | input | 1 | Result word valid |
| smp_data | input | RES_W | Conversion result |
| last_res | output | RES_W | Last raw result received |
| acc_q | output | ACC_W | Accumulator |
| cnt_q | output | CNT_W | Sample counter |
| ovf_q | output | 1 | Sticky accumulator overflow |
| filt_q | output | ACC_W | Filtered output |
| filt_vld | output | 1 | One-cycle pulse when filt_q is updated |
| prev_q | output | ACC_W | Previous-value register |

## Verification
The bench sends a shift field of 7 together with a 64-sample average. A design that does not clamp the field would divide by 128 and return half the mean. It also runs the accumulator through a carry-out to check that the overflow flag is set and stays set and that the sum wraps; a design that saturates the sum or lets the flag decay would be caught. A sample is deliberately injected while a clear is still pending, so a clear that finishes early or lets that sample through leaves a non-zero accumulator. Burst samples that arrive before a trigger must produce neither an output nor a change to the accumulator. Both previous-value sources are exercised, which separates a design that picks the wrong source or captures the result after the update.

// File: rtl/adc_pp_pkg.sv
package adc_pp_pkg;

   localparam logic [2:0] MD_BASIC = 3'd0;
   localparam logic [2:0] MD_ACCUM = 3'd1;
   localparam logic [2:0] MD_AVG   = 3'd2;
   localparam logic [2:0] MD_BURST = 3'd3;
   localparam logic [2:0] MD_LPF   = 3'd4;

   typedef struct packed {
      logic       clr;
      logic [2:0] shift;
      logic       prev_src;
      logic [2:0] mode;
   } pp_ctl_t;

endpackage

// File: rtl/adc_pp_ctrl.sv
module adc_pp_ctrl
   import adc_pp_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int CLR_CYC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  pp_ctl_t          ctl_wdata,
   input  logic             rpt_we,
   input  logic [CNT_W-1:0] rpt_wdata,
   output pp_ctl_t          ctl,
   output logic [CNT_W-1:0] rpt,
   output logic             clr_fire
);

   logic [2:0] mode_r, shift_r;
   logic       src_r, busy;
   logic       clr_req;

   assign clr_req = ctl_we && ctl_wdata.clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_r  <= '0;
         shift_r <= '0;
         src_r   <= 1'b0;
         rpt     <= '0;
         busy    <= 1'b0;
      end else begin
         if (ctl_we) begin
            mode_r  <= ctl_wdata.mode;
            shift_r <= ctl_wdata.shift;
            src_r   <= ctl_wdata.prev_src;
         end
         if (rpt_we)
            rpt <= rpt_wdata;
         if (clr_req)
            busy <= 1'b1;
         else if (clr_fire)
            busy <= 1'b0;
      end
   end

   generate
      if (CLR_CYC == 1) begin : g_clr_single
         assign clr_fire = busy;
      end else begin : g_clr_timer
         localparam int TW = $clog2(CLR_CYC);
         logic [TW-1:0] tmr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               tmr <= '0;
            else if (clr_req)
               tmr <= TW'(CLR_CYC - 1);
            else if (busy && tmr != '0)
               tmr <= tmr - 1'b1;
         end
         assign clr_fire = busy && (tmr == '0);
      end
   endgenerate

   assign ctl = '{clr: busy, shift: shift_r, prev_src: src_r, mode: mode_r};

   // R9: a clear request is visible as pending on the next cycle
   p_clr_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req |=> ctl.clr);

   // R9: the pending bit drops once the clear has fired
   p_clr_selfclear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_fire && !clr_req) |=> !ctl.clr);

endmodule

// File: rtl/adc_pp_accum.sv
module adc_pp_accum
   import adc_pp_pkg::*;
#(
   parameter int RES_W  = 10,
   parameter int ACC_W  = 16,
   parameter int CNT_W  = 8,
   parameter int MAX_SH = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [RES_W-1:0] smp_data,
   input  logic             conv_start,
   input  logic [2:0]       mode,
   input  logic [2:0]       shift,
   input  logic             busy,
   input  logic             clr_fire,
   input  logic [CNT_W-1:0] rpt,
   output logic [ACC_W-1:0] acc,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf,
   output logic [ACC_W-1:0] filt,
   output logic             out_vld
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [2:0]       sh;
   logic [ACC_W-1:0] smp_x;
   logic [ACC_W:0]   sum;
   logic [ACC_W-1:0] sum_lo;
   logic             carry;
   logic [ACC_W-1:0] lpf_nxt;
   logic [CNT_W-1:0] cnt_inc;
   logic             hit;
   logic             armed;
   logic             basic_md;

   assign sh       = (int'(shift) > MAX_SH) ? 3'(MAX_SH) : shift;
   assign smp_x    = ACC_W'(smp_data);
   assign sum      = {1'b0, acc} + {1'b0, smp_x};
   assign sum_lo   = sum[ACC_W-1:0];
   assign carry    = sum[ACC_W];
   assign lpf_nxt  = acc + smp_x - (acc >> sh);
   assign cnt_inc  = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
   assign hit      = (cnt_inc == rpt);
   assign basic_md = (mode == MD_BASIC) || (mode > MD_LPF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc     <= '0;
         cnt     <= '0;
         ovf     <= 1'b0;
         filt    <= '0;
         out_vld <= 1'b0;
         armed   <= 1'b0;
      end else begin
         out_vld <= 1'b0;
         if (clr_fire) begin
            acc <= '0;
            cnt <= '0;
            ovf <= 1'b0;
         end else if (conv_start && mode == MD_BURST) begin
            acc   <= '0;
            cnt   <= '0;
            armed <= 1'b1;
         end else if (smp_valid) begin
            if (basic_md) begin
               filt    <= smp_x;
               out_vld <= 1'b1;
            end else if (!busy) begin
               case (mode)
                  MD_ACCUM: begin
                     acc     <= sum_lo;
                     cnt     <= cnt_inc;
                     ovf     <= ovf | carry;
                     filt    <= sum_lo >> sh;
                     out_vld <= 1'b1;
                  end
                  MD_AVG, MD_BURST: begin
                     if (mode == MD_AVG || armed) begin
                        ovf <= ovf | carry;
                        if (hit) begin
                           filt    <= sum_lo >> sh;
                           out_vld <= 1'b1;
                           acc     <= '0;
                           cnt     <= '0;
                           if (mode == MD_BURST)
                              armed <= 1'b0;
                        end else begin
                           acc <= sum_lo;
                           cnt <= cnt_inc;
                        end
                     end
                  end
                  default: begin
                     acc     <= lpf_nxt;
                     cnt     <= cnt_inc;
                     filt    <= lpf_nxt >> sh;
                     out_vld <= 1'b1;
                  end
               endcase
            end
         end
      end
   end

   // R9: a completed clear leaves accumulator, counter and flag at zero
   p_clr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_fire |=> (acc == '0 && cnt == '0 && !ovf));

   // R8: overflow is sticky until a clear
   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr_fire) |=> ovf);

   // R2: pass-through copies the sample to the output
   p_basic_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && basic_md && !clr_fire) |=> (out_vld && filt == $past(smp_x)));

   // R4: an average result leaves the accumulator flushed
   p_avg_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && $past(mode) == MD_AVG) |-> (acc == '0 && cnt == '0));

   // R5: an unarmed burst ignores samples
   p_burst_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && mode == MD_BURST && !armed && !clr_fire && !conv_start)
      |=> ($stable(acc) && !out_vld));

endmodule

// File: rtl/adc_pp_prev.sv
module adc_pp_prev #(
   parameter int RES_W = 10,
   parameter int ACC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [RES_W-1:0] smp_data,
   input  logic             conv_start,
   input  logic             prev_src,
   input  logic [ACC_W-1:0] filt,
   output logic [RES_W-1:0] res_q,
   output logic [ACC_W-1:0] prev_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q  <= '0;
         prev_q <= '0;
      end else begin
         if (smp_valid)
            res_q <= smp_data;
         if (conv_start)
            prev_q <= prev_src ? filt : ACC_W'(res_q);
      end
   end

   // R10: raw source takes the result held before the start
   p_prev_raw_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_start && !prev_src) |=> prev_q == ACC_W'($past(res_q)));

   // R10: filtered source takes the output value
   p_prev_flt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_start && prev_src) |=> prev_q == $past(filt));

endmodule

// File: rtl/adc_postproc.sv
module adc_postproc
   import adc_pp_pkg::*;
#(
   parameter int RES_W   = 10,
   parameter int ACC_W   = 16,
   parameter int CNT_W   = 8,
   parameter int MAX_SH  = 6,
   parameter int CLR_CYC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [7:0]       ctl_wdata,
   output logic [7:0]       ctl_rdata,
   input  logic             rpt_we,
   input  logic [CNT_W-1:0] rpt_wdata,
   output logic [CNT_W-1:0] rpt_rdata,
   input  logic             conv_start,
   input  logic             smp_valid,
   input  logic [RES_W-1:0] smp_data,
   output logic [RES_W-1:0] last_res,
   output logic [ACC_W-1:0] acc_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             ovf_q,
   output logic [ACC_W-1:0] filt_q,
   output logic             filt_vld,
   output logic [ACC_W-1:0] prev_q
);

   initial begin
      assert (ACC_W >= RES_W + MAX_SH) else $error("ACC_W too small for RES_W and MAX_SH");
      assert (MAX_SH >= 1 && MAX_SH <= 7) else $error("MAX_SH out of range");
      assert (CLR_CYC >= 1) else $error("CLR_CYC must be at least 1");
      assert (CNT_W >= 1) else $error("CNT_W must be positive");
   end

   pp_ctl_t ctl;
   logic    clr_fire;

   adc_pp_ctrl #(.CNT_W(CNT_W), .CLR_CYC(CLR_CYC)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ctl_we),
      .ctl_wdata (pp_ctl_t'(ctl_wdata)),
      .rpt_we    (rpt_we),
      .rpt_wdata (rpt_wdata),
      .ctl       (ctl),
      .rpt       (rpt_rdata),
      .clr_fire  (clr_fire)
   );

   adc_pp_accum #(.RES_W(RES_W), .ACC_W(ACC_W), .CNT_W(CNT_W), .MAX_SH(MAX_SH)) u_accum (
      .clk        (clk),
      .rst_n      (rst_n),
      .smp_valid  (smp_valid),
      .smp_data   (smp_data),
      .conv_start (conv_start),
      .mode       (ctl.mode),
      .shift      (ctl.shift),
      .busy       (ctl.clr),
      .clr_fire   (clr_fire),
      .rpt        (rpt_rdata),
      .acc        (acc_q),
      .cnt        (cnt_q),
      .ovf        (ovf_q),
      .filt       (filt_q),
      .out_vld    (filt_vld)
   );

   adc_pp_prev #(.RES_W(RES_W), .ACC_W(ACC_W)) u_prev (
      .clk        (clk),
      .rst_n      (rst_n),
      .smp_valid  (smp_valid),
      .smp_data   (smp_data),
      .conv_start (conv_start),
      .prev_src   (ctl.prev_src),
      .filt       (filt_q),
      .res_q      (last_res),
      .prev_q     (prev_q)
   );

   assign ctl_rdata = ctl;

endmodule

// File: tb/test_adc_postproc.sv
module test_adc_postproc;

   localparam int RES_W   = 10;
   localparam int ACC_W   = 16;
   localparam int CNT_W   = 8;
   localparam int MAX_SH  = 6;
   localparam int CLR_CYC = 3;
   localparam int ACC_MOD = 1 << ACC_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ctl_we = 1'b0;
   logic [7:0]       ctl_wdata = '0;
   logic [7:0]       ctl_rdata;
   logic             rpt_we = 1'b0;
   logic [CNT_W-1:0] rpt_wdata = '0;
   logic [CNT_W-1:0] rpt_rdata;
   logic             conv_start = 1'b0;
   logic             smp_valid = 1'b0;
   logic [RES_W-1:0] smp_data = '0;
   logic [RES_W-1:0] last_res;
   logic [ACC_W-1:0] acc_q;
   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic [ACC_W-1:0] filt_q;
   logic             filt_vld;
   logic [ACC_W-1:0] prev_q;

   always #10 clk = ~clk;

   adc_postproc #(.RES_W(RES_W), .ACC_W(ACC_W), .CNT_W(CNT_W),
                  .MAX_SH(MAX_SH), .CLR_CYC(CLR_CYC)) i_adc_postproc (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .rpt_we(rpt_we), .rpt_wdata(rpt_wdata),
      .rpt_rdata(rpt_rdata), .conv_start(conv_start), .smp_valid(smp_valid),
      .smp_data(smp_data), .last_res(last_res), .acc_q(acc_q), .cnt_q(cnt_q),
      .ovf_q(ovf_q), .filt_q(filt_q), .filt_vld(filt_vld), .prev_q(prev_q)
   );

   typedef struct {
      int    val;
      string req;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   bit   finished = 1'b0;

   // model state
   int m_mode = 0, m_sh = 0, m_src = 0, m_rpt = 0;
   int m_acc = 0, m_cnt = 0, m_ovf = 0, m_filt = 0, m_res = 0, m_prev = 0;
   bit m_arm = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic push_exp(input int v, input string req);
      exp_t e;
      e.val = v;
      e.req = req;
      exp_q.push_back(e);
      m_filt = v;
   endtask

   // monitor: pops expected outputs as the design produces them
   always @(negedge clk) begin
      if (rst_n && filt_vld) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2-R6", "unexpected filt_vld, filt_q", int'(filt_q), -1);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(int'(filt_q) == e.val, e.req, "filt_q", int'(filt_q), e.val);
         end
      end
   end

   task automatic wr_ctl(input int md, input int sh, input int src, input bit clr);
      @(negedge clk);
      ctl_we    = 1'b1;
      ctl_wdata = {clr, 3'(sh), 1'(src), 3'(md)};
      @(negedge clk);
      ctl_we = 1'b0;
      m_mode = md; m_sh = sh; m_src = src;
   endtask

   task automatic wr_rpt(input int v);
      @(negedge clk);
      rpt_we    = 1'b1;
      rpt_wdata = CNT_W'(v);
      @(negedge clk);
      rpt_we = 1'b0;
      m_rpt = v;
   endtask

   function automatic int eff_sh();
      return (m_sh > MAX_SH) ? MAX_SH : m_sh;
   endfunction

   task automatic send(input int d);
      int nxt;
      int s;
      s = eff_sh();
      case (m_mode)
         1: begin
            nxt = m_acc + d;
            if (nxt >= ACC_MOD) begin m_ovf = 1; nxt -= ACC_MOD; end
            m_acc = nxt;
            if (m_cnt < 255) m_cnt++;
            push_exp(nxt >> s, "R3");
         end
         2, 3: begin
            if (m_mode == 2 || m_arm) begin
               nxt = m_acc + d;
               if (nxt >= ACC_MOD) begin m_ovf = 1; nxt -= ACC_MOD; end
               if (m_cnt + 1 == m_rpt) begin
                  push_exp(nxt >> s, (m_mode == 2) ? "R4" : "R5");
                  m_acc = 0; m_cnt = 0;
                  if (m_mode == 3) m_arm = 1'b0;
               end else begin
                  m_acc = nxt;
                  if (m_cnt < 255) m_cnt++;
               end
            end
         end
         4: begin
            m_acc = (m_acc + d - (m_acc >> s)) % ACC_MOD;
            if (m_cnt < 255) m_cnt++;
            push_exp(m_acc >> s, "R6");
         end
         default: push_exp(d, "R2");
      endcase
      m_res = d;
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = RES_W'(d);
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic start();
      @(negedge clk);
      conv_start = 1'b1;
      @(negedge clk);
      conv_start = 1'b0;
      if (m_mode == 3) begin m_acc = 0; m_cnt = 0; m_arm = 1'b1; end
      m_prev = m_src ? m_filt : m_res;
   endtask

   task automatic chk_state(input string req);
      chk(int'(acc_q) == m_acc, req, "acc_q", int'(acc_q), m_acc);
      chk(int'(cnt_q) == m_cnt, req, "cnt_q", int'(cnt_q), m_cnt);
      chk(int'(ovf_q) == m_ovf, req, "ovf_q", int'(ovf_q), m_ovf);
   endtask

   // clear with one sample injected while pending (R9)
   task automatic do_clear(input int inject);
      int held;
      held = int'(acc_q);
      wr_ctl(m_mode, m_sh, m_src, 1'b1);
      chk(ctl_rdata[7] == 1'b1, "R9", "clear pending bit", int'(ctl_rdata[7]), 1);
      smp_valid = 1'b1;
      smp_data  = RES_W'(inject);
      m_res = inject;
      @(negedge clk);
      smp_valid = 1'b0;
      chk(int'(acc_q) == held, "R9", "acc during pending clear", int'(acc_q), held);
      repeat (CLR_CYC - 2) @(negedge clk);
      chk(ctl_rdata[7] == 1'b1, "R9", "clear still pending", int'(ctl_rdata[7]), 1);
      @(negedge clk);
      chk(ctl_rdata[7] == 1'b0, "R9", "clear bit self-cleared", int'(ctl_rdata[7]), 0);
      m_acc = 0; m_cnt = 0; m_ovf = 0;
      chk_state("R9");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(ctl_rdata == 8'h00, "R1", "ctl_rdata", int'(ctl_rdata), 0);
      chk(rpt_rdata == '0, "R1", "rpt_rdata", int'(rpt_rdata), 0);
      chk(filt_q == '0 && !filt_vld, "R1", "filt_q/filt_vld", int'(filt_q), 0);
      chk(prev_q == '0, "R1", "prev_q", int'(prev_q), 0);
      chk_state("R1");

      // R2: pass-through from reset, shift field ignored
      send(100);
      wr_ctl(0, 5, 0, 1'b0);
      send(1023);
      chk_state("R2");
      wr_ctl(6, 3, 0, 1'b0);
      send(7);
      chk_state("R2");

      // R11: register layout readback
      wr_ctl(1, 2, 1, 1'b0);
      chk(ctl_rdata == 8'h29, "R11", "ctl_rdata", int'(ctl_rdata), 'h29);

      // R3: accumulate
      send(10); chk_state("R3");
      send(20); chk_state("R3");
      send(30); chk_state("R3");

      // R9: clear while accumulating, one sample ignored
      do_clear(5);

      // R4: average, threshold 4, shift 2
      wr_ctl(2, 2, 0, 1'b0);
      wr_rpt(4);
      chk(int'(rpt_rdata) == 4, "R11", "rpt_rdata", int'(rpt_rdata), 4);
      send(4); send(8); send(12); chk_state("R4");
      send(16); chk_state("R4");
      send(1); send(2); send(3); send(5); chk_state("R4");

      // R7: shift field 7 acts as 6 with 64-sample average
      wr_ctl(2, 7, 0, 1'b0);
      wr_rpt(64);
      for (int i = 0; i < 64; i++) send(100);
      chk(m_filt == 100, "R7", "model mean", m_filt, 100);
      chk_state("R7");

      // R5: burst
      wr_ctl(3, 1, 0, 1'b0);
      wr_rpt(2);
      send(50); chk_state("R5");
      start();
      send(6); send(8); chk_state("R5");
      send(9); chk_state("R5");

      // R10: raw previous source, last raw was 9
      start();
      chk(int'(prev_q) == m_prev, "R10", "prev_q raw", int'(prev_q), m_prev);

      // R6: low-pass filter after a clear
      do_clear(11);
      wr_ctl(4, 2, 1, 1'b0);
      send(100); send(100); send(100);
      chk_state("R6");
      start();
      chk(int'(prev_q) == m_prev, "R10", "prev_q filtered", int'(prev_q), m_prev);
      wr_ctl(4, 2, 0, 1'b0);
      start();
      chk(int'(prev_q) == 100, "R10", "prev_q raw after filter", int'(prev_q), 100);

      // R8: overflow in accumulate mode
      do_clear(3);
      wr_ctl(1, 1, 0, 1'b0);
      for (int i = 0; i < 64; i++) send(1023);
      chk(ovf_q == 1'b0, "R8", "ovf before carry", int'(ovf_q), 0);
      send(1023);
      chk_state("R8");
      send(1023);
      chk(ovf_q == 1'b1, "R8", "ovf sticky", int'(ovf_q), 1);
      do_clear(2);

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R2-R6", "outstanding expected outputs", exp_q.size(), 0);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule